// File: doc/BRIEF.md
# Password-Protected Watchdog Timer

This block is a memory-mapped watchdog peripheral. Software programs it over a simple 32-bit register port with valid, write-enable, address and data. The control word holds an enable bit, a pre-warning threshold code, a prescaler select and a 16-bit reload value. A change to the control word only takes effect when it arrives as the second write of a two-step key sequence. Starting, refreshing, stopping and reconfiguring the timer all go through that sequence, so a stray store cannot disturb a running watchdog.

While the timer runs, a prescaler divides the clock into ticks, and each tick decrements a 16-bit counter. A pre-warning output rises once the remaining count falls to a programmed fraction of the full 16-bit range. When the count runs out, the block emits a one-cycle reset request and halts the counter. It also sets a sticky reset-cause flag. A system reset does not clear this flag; only power-on reset does, so boot software can tell that the watchdog caused the restart.

Top module: `pwd_watchdog`

## Requirements
- R1: After reset, the control word, status word and reset-cause word all read 0, and both `prewarn_o` and `wdt_reset_o` are low.
- R2: Unlock and commit. A write to byte address 0x0 with key 0xBE in bits 23:16 arms the unlock. If the next bus access is a write to 0x0 with key 0xDC in bits 23:16, that write is committed. The commit loads enable (bit 31), the warning code (bits 27:26), the prescaler select (bits 25:24) and the reload value (bits 15:0).
- R3: Broken sequences are ignored. Any bus access that is neither an arming write nor the committing write leaves the control word unchanged and disarms the unlock. This covers a key-0xDC write without prior arming, an arming write followed by a write with another key, and an arming write followed by a read.
- R4: The control word at 0x0 reads back bit 31, bits 27:24 and bits 15:0 as committed. All other bits, including the key field 23:16, read as 0.
- R5: The status word at 0x8 shows the running state in bit 31 and the current count in bits 15:0. The reset-cause word at 0xC shows the flag in bit 31. All other bits and addresses read as 0.
- R6: While running, the counter decrements once every 2^DIVn_LOG2 clock cycles, where n is the prescaler select code. The defaults for codes 0, 1, 2 and 3 divide by 1, 64, 4096 and 262144. A commit restarts the prescaler phase.
- R7: `prewarn_o` is high exactly when the timer is running and the count is at most 0xFFFF shifted right by (code+1). Codes 0, 1, 2 and 3 give 1/2, 1/4, 1/8 and 1/16 of the full range.
- R8: When a tick finds the count at 1 or 0, the count becomes 0 and the timer stops. `wdt_reset_o` then pulses high for exactly one cycle, and the count holds at 0 until the next commit.
- R9: The reset-cause flag sets one cycle after the reset pulse. It survives `rst_n` and is cleared only by `por_n`.
- R10: A commit with enable set loads the reload value and starts the timer. If that commit falls on the same cycle as an expiring tick, the commit wins: no reset pulse occurs and the count takes the new value.
- R11: A commit with enable clear stops the timer. The count freezes at its current value, `prewarn_o` drops, and no reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active low, clears everything |
| rst_n | input | 1 | System reset, asynchronous active low, keeps the reset-cause flag |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prewarn_o | output | 1 | Pre-warning level |
| wdt_reset_o | output | 1 | One-cycle reset request on expiry |

## Verification
Two functions can land in one cycle: the committing write of a refresh and the tick that would expire the counter. The bench arms the unlock one cycle early, so that the commit lands on exactly the edge where the count would go from 1 to 0. It then judges the result in two ways. A pulse monitor must see no reset request, and the status word must show the new reload value with the running bit set. A cycle-by-cycle behavioural model gives the same outcome from the written priority rule, and the bench compares it with the outputs on every clock.

// File: rtl/pwd_wdt_pkg.sv
package pwd_wdt_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned BUS_W = 32;
  localparam logic [7:0] KEY_ARM    = 8'hBE;
  localparam logic [7:0] KEY_COMMIT = 8'hDC;

  typedef struct packed {
    logic             en;
    logic [1:0]       warn_sel;
    logic [1:0]       div_sel;
    logic [CNT_W-1:0] reload;
  } wdt_cfg_t;

  function automatic wdt_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
    wdt_cfg_t c;
    c.en       = w[31];
    c.warn_sel = w[27:26];
    c.div_sel  = w[25:24];
    c.reload   = w[15:0];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] word_from_cfg(input wdt_cfg_t c);
    return {c.en, 3'b000, c.warn_sel, c.div_sel, 8'h00, c.reload};
  endfunction
endpackage

// File: rtl/pwd_wdt_unlock.sv
module pwd_wdt_unlock
  import pwd_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_i,
  input  logic       ctrl_hit_i,
  input  logic       wr_i,
  input  logic [7:0] key_i,
  output logic       commit_o
);
  logic armed_q, armed_d;
  logic arm_wr;

  assign arm_wr = acc_i && ctrl_hit_i && wr_i && (key_i == KEY_ARM);

  always_comb begin
    armed_d  = armed_q;
    commit_o = 1'b0;
    if (acc_i) begin
      if (arm_wr) begin
        armed_d = 1'b1;
      end else begin
        commit_o = armed_q && ctrl_hit_i && wr_i && (key_i == KEY_COMMIT);
        armed_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R3: an access that is not an arming write leaves nothing to commit next cycle
  a_r3_disarm_on_other_access: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && !arm_wr) |=> !commit_o);
endmodule

// File: rtl/pwd_wdt_prescaler.sv
module pwd_wdt_prescaler #(
  parameter int unsigned DIV0_LOG2 = 0,
  parameter int unsigned DIV1_LOG2 = 6,
  parameter int unsigned DIV2_LOG2 = 12,
  parameter int unsigned DIV3_LOG2 = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  localparam int unsigned MAX01 = (DIV0_LOG2 > DIV1_LOG2) ? DIV0_LOG2 : DIV1_LOG2;
  localparam int unsigned MAX23 = (DIV2_LOG2 > DIV3_LOG2) ? DIV2_LOG2 : DIV3_LOG2;
  localparam int unsigned MAXL  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned PW    = (MAXL < 1) ? 1 : MAXL;
  localparam logic [PW-1:0] M0 = PW'((64'd1 << DIV0_LOG2) - 64'd1);
  localparam logic [PW-1:0] M1 = PW'((64'd1 << DIV1_LOG2) - 64'd1);
  localparam logic [PW-1:0] M2 = PW'((64'd1 << DIV2_LOG2) - 64'd1);
  localparam logic [PW-1:0] M3 = PW'((64'd1 << DIV3_LOG2) - 64'd1);

  logic [PW-1:0] pre_q, pre_d, mask;

  always_comb begin
    case (sel_i)
      2'd0:    mask = M0;
      2'd1:    mask = M1;
      2'd2:    mask = M2;
      default: mask = M3;
    endcase
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_comb begin
    pre_d = pre_q;
    if (clear_i)    pre_d = '0;
    else if (run_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pwd_wdt_countdown.sv
module pwd_wdt_countdown
  import pwd_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [1:0]       warn_sel_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expire_o,
  output logic             prewarn_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] count_q, count_d, thresh;
  logic             run_q, run_d, pulse_q, pulse_d;

  always_comb begin
    count_d = count_q;
    run_d   = run_q;
    pulse_d = 1'b0;
    if (load_i) begin
      run_d = load_en_i;
      if (load_en_i) count_d = load_val_i;
    end else if (run_q && tick_i) begin
      if (count_q <= CNT_W'(1)) begin
        count_d = '0;
        run_d   = 1'b0;
        pulse_d = 1'b1;
      end else begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      count_q <= count_d;
      run_q   <= run_d;
      pulse_q <= pulse_d;
    end
  end

  assign thresh    = FULL >> ({1'b0, warn_sel_i} + 3'd1);
  assign prewarn_o = run_q && (count_q <= thresh);
  assign count_o   = count_q;
  assign run_o     = run_q;
  assign expire_o  = pulse_q;

  // R8: the reset request lasts exactly one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R8: during the pulse the timer is halted at zero
  a_r8_halted_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (!run_q && count_q == '0));
  // R11: a stopped timer keeps its count until the next commit
  a_r11_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> $stable(count_q));
endmodule

// File: rtl/pwd_watchdog.sv
module pwd_watchdog
  import pwd_wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DIV0_LOG2 = 0,
  parameter int unsigned DIV1_LOG2 = 6,
  parameter int unsigned DIV2_LOG2 = 12,
  parameter int unsigned DIV3_LOG2 = 18
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              prewarn_o,
  output logic              wdt_reset_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(12);
  localparam int unsigned       SYNC_N    = 2;

  // reset synchronisers: index 0 = power-on domain, index 1 = system domain
  logic [1:0] raw_rst_n;
  logic [1:0] synced_rst_n;
  assign raw_rst_n[0] = por_n;
  assign raw_rst_n[1] = rst_n & por_n;

  for (genvar g = 0; g < 2; g++) begin : g_rst_sync
    logic [SYNC_N-1:0] stage_q;
    always_ff @(posedge clk or negedge raw_rst_n[g]) begin
      if (!raw_rst_n[g]) stage_q <= '0;
      else               stage_q <= {stage_q[SYNC_N-2:0], 1'b1};
    end
    assign synced_rst_n[g] = stage_q[SYNC_N-1];
  end

  logic por_rst_n, sys_rst_n;
  assign por_rst_n = synced_rst_n[0];
  assign sys_rst_n = synced_rst_n[1];

  logic             ctrl_hit, commit, tick, running, expire, cause_q, cause_d;
  logic [CNT_W-1:0] count;
  wdt_cfg_t         cfg_q, cfg_d, cfg_wr;

  assign ctrl_hit = (bus_addr == OFS_CTRL);
  assign cfg_wr   = cfg_from_word(bus_wdata);

  pwd_wdt_unlock u_unlock (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .acc_i     (bus_valid),
    .ctrl_hit_i(ctrl_hit),
    .wr_i      (bus_write),
    .key_i     (bus_wdata[23:16]),
    .commit_o  (commit)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (commit) cfg_d = cfg_wr;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  pwd_wdt_prescaler #(
    .DIV0_LOG2(DIV0_LOG2), .DIV1_LOG2(DIV1_LOG2),
    .DIV2_LOG2(DIV2_LOG2), .DIV3_LOG2(DIV3_LOG2)
  ) u_prescaler (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .run_i  (running),
    .clear_i(commit),
    .sel_i  (cfg_q.div_sel),
    .tick_o (tick)
  );

  pwd_wdt_countdown u_countdown (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .load_i    (commit),
    .load_en_i (cfg_wr.en),
    .load_val_i(cfg_wr.reload),
    .tick_i    (tick),
    .warn_sel_i(cfg_q.warn_sel),
    .count_o   (count),
    .run_o     (running),
    .expire_o  (expire),
    .prewarn_o (prewarn_o)
  );

  assign cause_d = cause_q | expire;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) cause_q <= 1'b0;
    else            cause_q <= cause_d;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = word_from_cfg(cfg_q);
      OFS_STAT:  bus_rdata = {running, 15'd0, count};
      OFS_CAUSE: bus_rdata = {cause_q, 31'd0};
      default:   bus_rdata = '0;
    endcase
  end

  assign wdt_reset_o = expire;

  // R9: once set, the cause flag stays set until power-on reset
  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!por_rst_n)
    cause_q |=> cause_q);
  // R9: a reset request is always followed by the cause flag
  a_r9_cause_follows_pulse: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wdt_reset_o |=> cause_q);
endmodule

// File: tb/pwd_watchdog_tb.sv
module pwd_watchdog_tb;
  localparam int PERIOD = 10;
  localparam int AW = 4;

  logic clk, por_n, rst_n, bus_valid, bus_write;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic prewarn_o, wdt_reset_o;

  pwd_watchdog #(.ADDR_W(AW), .DIV0_LOG2(0), .DIV1_LOG2(1), .DIV2_LOG2(2), .DIV3_LOG2(3)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .prewarn_o(prewarn_o), .wdt_reset_o(wdt_reset_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, pulses = 0;
  bit cmp_on = 0;

  // behavioural reference model
  int m_armed, m_en, m_warn, m_div, m_reload, m_run, m_cnt, m_pre, m_pulse, m_cause;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    int key, dv;
    bit commit;
    if (!por_n) m_cause = 0;
    if (!rst_n || !por_n) begin
      m_armed = 0; m_en = 0; m_warn = 0; m_div = 0; m_reload = 0;
      m_run = 0; m_cnt = 0; m_pre = 0; m_pulse = 0;
    end else begin
      key = int'(bus_wdata[23:16]);
      commit = 0;
      if (m_pulse) m_cause = 1;
      if (bus_valid) begin
        if (bus_write && bus_addr == 0 && key == 'hBE) m_armed = 1;
        else begin
          if (bus_write && bus_addr == 0 && key == 'hDC && m_armed) commit = 1;
          m_armed = 0;
        end
      end
      m_pulse = 0;
      if (commit) begin
        m_en = int'(bus_wdata[31]); m_warn = int'(bus_wdata[27:26]);
        m_div = int'(bus_wdata[25:24]); m_reload = int'(bus_wdata[15:0]);
        m_pre = 0;
        if (m_en != 0) begin m_run = 1; m_cnt = m_reload; end
        else m_run = 0;
      end else if (m_run != 0) begin
        dv = 1 << m_div;
        if (m_pre % dv == dv - 1) begin
          if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_pulse = 1; end
          else m_cnt = m_cnt - 1;
        end
        m_pre = m_pre + 1;
      end
    end
  end

  function automatic logic [31:0] m_rdata(input logic [AW-1:0] a);
    if (a == 0) return {m_en[0], 3'b0, m_warn[1:0], m_div[1:0], 8'h00, m_reload[15:0]};
    if (a == 8) return {m_run[0], 15'd0, m_cnt[15:0]};
    if (a == 12) return {m_cause[0], 31'd0};
    return 32'd0;
  endfunction

  function automatic bit m_prewarn();
    return (m_run != 0) && (m_cnt <= (65535 >> (m_warn + 1)));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R2..R11 in aggregate)
  always @(negedge clk) begin
    if (wdt_reset_o === 1'b1) pulses++;
    if (cmp_on) begin
      check("R7 prewarn per cycle", {31'd0, prewarn_o}, {31'd0, m_prewarn()});
      check("R8 reset pulse per cycle", {31'd0, wdt_reset_o}, {31'd0, m_pulse[0]});
      check("R5 read data per cycle", bus_rdata, m_rdata(bus_addr));
    end
  end

  task automatic go_idle();
    bus_valid = 0; bus_write = 0; bus_addr = AW'(8); bus_wdata = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; go_idle();
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1; go_idle();
  endtask
  task automatic unlock(input logic [31:0] cfg);
    wr(0, 32'h00BE0000);
    wr(0, (cfg & 32'hFF00FFFF) | 32'h00DC0000);
  endtask
  task automatic peek(input logic [AW-1:0] a, output logic [31:0] v);
    bus_addr = a; @(negedge clk); v = bus_rdata; @(posedge clk); #1; go_idle();
  endtask

  bit done = 0;

  initial begin
    logic [31:0] v, v2;
    int p0;
    go_idle(); por_n = 0; rst_n = 0;
    idle(3); cmp_on = 1;
    por_n = 1; rst_n = 1;
    idle(4);

    // R1 reset state
    rd(0, v);  check("R1 control after reset", v, 32'h0);
    rd(8, v);  check("R1 status after reset", v, 32'h0);
    rd(12, v); check("R1 cause after reset", v, 32'h0);
    check("R1 outputs low", {30'd0, prewarn_o, wdt_reset_o}, 32'h0);

    // R2 / R4 commit a disabled configuration, key field reads zero
    unlock(32'h0E001234);
    rd(0, v); check("R2 R4 committed control readback", v, 32'h0E001234);
    rd(8, v); check("R2 stays stopped with enable clear", v, 32'h0);

    // R3 broken sequences
    wr(0, 32'h00BE0000); wr(0, 32'h80AA0077); wr(0, 32'h80DC0077);
    rd(0, v); check("R3 wrong second key", v, 32'h0E001234);
    wr(0, 32'h80DC0077);
    rd(0, v); check("R3 commit key without arming", v, 32'h0E001234);
    wr(0, 32'h00BE0000); rd(0, v2); wr(0, 32'h80DC0077);
    rd(0, v); check("R3 read between keys", v, 32'h0E001234);
    wr(0, 32'h00BE0000); rd(8, v2); wr(0, 32'h80DC0077);
    rd(0, v); check("R3 status read between keys", v, 32'h0E001234);

    // R8 / R9 expiry with divide by 1
    p0 = pulses;
    unlock(32'h80000005);
    idle(10);
    check("R8 one pulse on expiry", pulses - p0, 1);
    rd(8, v);  check("R8 halted at zero", v, 32'h0);
    rd(12, v); check("R9 cause set", v, 32'h80000000);

    // R6 divide by 8 (select 3): ticks on the 8th and 16th edge after commit
    unlock(32'h83000004);
    idle(16);
    peek(8, v); check("R6 count after 16 cycles at div 8", v, 32'h80000002);
    p0 = pulses;
    idle(20);
    check("R6 expiry after 32 cycles", pulses - p0, 1);

    // R7 pre-warning at code 3 (threshold 0x0FFF)
    unlock(32'h8C001002);
    @(negedge clk); check("R7 above threshold", {31'd0, prewarn_o}, 32'h0);
    @(posedge clk); #1; idle(2);
    @(negedge clk); check("R7 at threshold", {31'd0, prewarn_o}, 32'h1);
    @(posedge clk); #1;

    // R11 stop freezes the count
    unlock(32'h0C000000);
    rd(8, v); idle(5); rd(8, v2);
    check("R11 stopped not running", {31'd0, v[31]}, 32'h0);
    check("R11 count frozen", v2, v);
    check("R11 prewarn low when stopped", {31'd0, prewarn_o}, 32'h0);

    // R10 refresh landing on the expiring tick
    p0 = pulses;
    unlock(32'h80000003);
    idle(1);
    wr(0, 32'h00BE0000);
    wr(0, 32'h80DC0010);
    peek(8, v); check("R10 refresh wins over expiry", v, 32'h80000010);
    check("R10 no pulse on collision", pulses - p0, 0);
    unlock(32'h00000000);

    // R9 cause survives system reset, cleared by power-on reset
    rst_n = 0; idle(2); rst_n = 1; idle(4);
    rd(12, v); check("R9 cause kept over rst_n", v, 32'h80000000);
    rd(0, v);  check("R1 control cleared by rst_n", v, 32'h0);
    por_n = 0; idle(2); por_n = 1; idle(4);
    rd(12, v); check("R9 cause cleared by por_n", v, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule